// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

This block is a single-stage 32-bit integer unit for a shader-style ALU. It carries out three bit-field operations on register operands:

- **Signed extract** takes a field from a word and sign-extends it.
- **Unsigned extract** takes a field from a word and zero-extends it.
- **Insert** writes the low bits of one word into a field of another word.

An operation select picks the operation. Four operands go in: a base word, an insert word, a field offset and a field width. Only the low five bits of the offset and the width are used.

One transaction is accepted on every cycle in which the input strobe is high. The result and its strobe appear one clock edge later. The result register keeps its value while no transaction arrives.

Top module: `bfx_unit`

## Requirements
- R1: The select `op` is decoded as follows: 2'b00 is signed extract, 2'b01 is unsigned extract and 2'b10 is insert. Code 2'b11 produces a result of 0.
- R2: Only `field_off[4:0]` and `field_len[4:0]` are used. Bits 31:5 of both ports have no effect on the result.
- R3: Either extract with a field width of 0 returns 0.
- R4: Signed extract with 0 < width and offset+width < 32 returns bits [offset+width-1:offset] of `src_val`. Bit offset+width-1 is copied into every higher result bit.
- R5: Unsigned extract with 0 < width and offset+width < 32 returns the same field, with zeros in every higher result bit.
- R6: Either extract with width > 0 and offset+width >= 32 returns `src_val` shifted right by the offset. The shift is arithmetic for signed extract and logical for unsigned extract.
- R7: Insert returns `src_val` with bits [offset+width-1:offset] replaced by bits [width-1:0] of `src_ins`. All other bits are unchanged.
- R8: Insert with a width of 0 returns `src_val` unchanged.
- R9: In an insert with offset+width > 32, only the bits from the offset up to bit 31 are replaced. Field bits that would land above bit 31 are dropped.
- R10: `res_valid` and `res_data` update on the clock edge after a cycle with `in_valid` high. `res_valid` is low after a cycle with `in_valid` low, and `res_data` holds its value then. The synchronous active-high `rst` clears `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A transaction is present this cycle |
| op | input | 2 | Operation select |
| src_val | input | 32 | Value to extract from, or base to insert into |
| src_ins | input | 32 | Source of the inserted bits |
| field_off | input | 32 | Field offset; low 5 bits used |
| field_len | input | 32 | Field width; low 5 bits used |
| res_valid | output | 1 | Result is valid |
| res_data | output | 32 | Operation result |

## Verification
The whole block is combinational logic in front of one register. A wrong shift amount, a wrong mask bit or a wrong choice between the in-range path and the fallback path therefore shows up in `res_data` on the very next edge, for the specific offset and width that trigger it.

The bench sweeps every offset and width for each operation, using several value patterns, so each such fault turns up at the port. It also flips the ignored upper operand bits, so that any leak from them is seen.

A fault in the strobe or in the hold logic shows as a wrong `res_valid`, or as a `res_data` that changes in an idle cycle.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  typedef enum logic [1:0] {
    BFX_SEXT   = 2'b00,
    BFX_UEXT   = 2'b01,
    BFX_INSERT = 2'b10,
    BFX_NONE   = 2'b11
  } bfx_op_e;
endpackage

// File: rtl/bfx_extract.sv
module bfx_extract #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  value,
  input  logic [SW-1:0] off,
  input  logic [SW-1:0] len,
  input  logic          is_signed,
  output logic          fits,
  output logic [W-1:0]  result
);
  localparam logic [SW:0] W_L = (SW+1)'(W);

  logic [SW:0] span, lift_amt, drop_amt;
  logic [W-1:0] lifted, narrow, wide;

  assign span     = {1'b0, off} + {1'b0, len};
  assign fits     = span < W_L;
  assign lift_amt = W_L - span;
  assign drop_amt = W_L - {1'b0, len};
  assign lifted   = value << lift_amt;

  // In-range path: push the field to the top, then bring it back down.
  assign narrow = is_signed ? $unsigned($signed(lifted) >>> drop_amt)
                            : (lifted >> drop_amt);
  // Field runs past the top bit: plain shift by the offset.
  assign wide   = is_signed ? $unsigned($signed(value) >>> off)
                            : (value >> off);

  always_comb begin
    if (len == '0)  result = '0;
    else if (fits)  result = narrow;
    else            result = wide;
  end
endmodule

// File: rtl/bfx_insert.sv
module bfx_insert #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  base,
  input  logic [W-1:0]  ins,
  input  logic [SW-1:0] off,
  input  logic [SW-1:0] len,
  output logic [W-1:0]  mask,
  output logic [W-1:0]  result
);
  logic [SW:0]  span;
  logic [W-1:0] placed;

  assign span   = {1'b0, off} + {1'b0, len};
  assign placed = ins << off;

  // Per-bit window compare; positions at or above W never exist, so overflow drops out.
  for (genvar j = 0; j < W; j++) begin : g_mask
    localparam logic [SW:0] POS = (SW+1)'(j);
    assign mask[j] = ({1'b0, off} <= POS) && (POS < span);
  end

  assign result = (placed & mask) | (base & ~mask);
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] src_ins,
  input  logic [DATA_W-1:0] field_off,
  input  logic [DATA_W-1:0] field_len,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);
  localparam int SW = $clog2(DATA_W);

  bfx_op_e          op_e;
  logic [SW-1:0]    off_t, len_t;
  logic             ext_fits;
  logic [DATA_W-1:0] ext_res, ins_res, ins_mask, next_res;
  logic             unused_opnd_hi;

  assign op_e  = bfx_op_e'(op);
  assign off_t = field_off[SW-1:0];
  assign len_t = field_len[SW-1:0];
  assign unused_opnd_hi = ^{field_off[DATA_W-1:SW], field_len[DATA_W-1:SW]};

  bfx_extract #(.W(DATA_W), .SW(SW)) u_extract (
    .value(src_val), .off(off_t), .len(len_t),
    .is_signed(op_e == BFX_SEXT), .fits(ext_fits), .result(ext_res)
  );

  bfx_insert #(.W(DATA_W), .SW(SW)) u_insert (
    .base(src_val), .ins(src_ins), .off(off_t), .len(len_t),
    .mask(ins_mask), .result(ins_res)
  );

  always_comb begin
    unique case (op_e)
      BFX_SEXT, BFX_UEXT: next_res = ext_res;
      BFX_INSERT:         next_res = ins_res;
      default:            next_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_data <= next_res;
    end
  end

  // Assertions
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && $stable(res_data)));
  assert_unused_op_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11) |=> res_data == '0);
  assert_extract_zero_len_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op[1] && len_t == '0) |=> res_data == '0);
  assert_insert_zero_len_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b10 && len_t == '0) |=> res_data == $past(src_val));
  assert_uext_high_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b01 && ext_fits && len_t != '0)
      |=> (res_data >> $past(len_t)) == '0);
  assert_insert_mask_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b10) |-> ($countones(ins_mask) <= int'(len_t)));
endmodule

// File: tb/bfx_unit_bench.sv
module bfx_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  op;
  logic [31:0] src_val, src_ins, field_off, field_len;
  logic        res_valid;
  logic [31:0] res_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfx_unit u_bfx_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .src_val(src_val), .src_ins(src_ins),
    .field_off(field_off), .field_len(field_len),
    .res_valid(res_valid), .res_data(res_data)
  );

  // Bit-by-bit model of the requirements.
  function automatic logic [31:0] model(input logic [1:0] o, input logic [31:0] v,
                                        input logic [31:0] s, input logic [31:0] offw,
                                        input logic [31:0] lenw);
    int off, len, w;
    logic [31:0] r;
    off = int'(offw[4:0]);
    len = int'(lenw[4:0]);
    r = '0;
    if (o == 2'b00 || o == 2'b01) begin
      if (len != 0) begin
        w = (off + len < 32) ? len : 32 - off;
        for (int i = 0; i < 32; i++)
          if (i < w) r[i] = v[off + i];
          else       r[i] = (o == 2'b00) ? v[off + w - 1] : 1'b0;
      end
    end else if (o == 2'b10) begin
      for (int j = 0; j < 32; j++)
        r[j] = (j >= off && j < off + len) ? s[j - off] : v[j];
    end
    return r;
  endfunction

  function automatic string tag_for(input logic [1:0] o, input int off, input int len);
    if (o == 2'b11) return "R1";
    if (o == 2'b10) return (len == 0) ? "R8" : (off + len > 32) ? "R9" : "R7";
    if (len == 0) return "R3";
    if (off + len >= 32) return "R6";
    return (o == 2'b00) ? "R4" : "R5";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [1:0] o, input logic [31:0] v,
                        input logic [31:0] s, input logic [31:0] offw, input logic [31:0] lenw);
    @(negedge clk);
    in_valid = 1'b1; op = o; src_val = v; src_ins = s;
    field_off = offw; field_len = lenw;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'b0, res_valid}, 32'd1);
    check(tag, res_data, model(o, v, s, offw, lenw));
  endtask

  initial begin
    logic [31:0] vals [3];
    logic [31:0] held;
    vals[0] = 32'hA5C3_F00F;
    vals[1] = 32'h7FFF_0001;
    vals[2] = 32'h8000_7FFE;
    rst = 1'b1; in_valid = 1'b0; op = 2'b00;
    src_val = '0; src_ins = '0; field_off = '0; field_len = '0;
    repeat (3) @(negedge clk);
    check("R10 reset valid", {31'b0, res_valid}, 32'd0);
    rst = 1'b0;

    for (int o = 0; o < 3; o++)
      for (int p = 0; p < 3; p++)
        for (int off = 0; off < 32; off++)
          for (int len = 0; len < 32; len++)
            run_op(tag_for(2'(o), off, len), 2'(o), vals[p], ~vals[(p + 1) % 3],
                   32'(off), 32'(len));

    // R2: upper operand bits are garbage and must not matter.
    for (int k = 0; k < 64; k++) begin
      logic [31:0] offw, lenw;
      offw = {27'h5A5A5A5 ^ 27'(k * 7919), 5'(k)};
      lenw = {27'h3C3C3C3 ^ 27'(k * 104729), 5'(k * 3)};
      run_op("R2", 2'(k % 3), vals[k % 3], vals[(k + 2) % 3], offw, lenw);
    end

    // R1: unused code returns zero.
    run_op("R1", 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd4, 32'd8);

    // R10: idle cycle keeps data and drops valid.
    run_op("R10", 2'b01, 32'h1234_5678, 32'h0, 32'd4, 32'd12);
    held = res_data;
    @(negedge clk);
    src_val = 32'hFFFF_FFFF; field_len = 32'd31;
    @(negedge clk);
    check("R10 idle valid", {31'b0, res_valid}, 32'd0);
    check("R10 idle hold", res_data, held);
    check("R10 hold value", held, 32'h0000_0567);
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles >= WATCHDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      done = 1'b1;
    end
  end

  initial begin
    wait (done);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule